// File: doc/BRIEF.md
# Scaled Min-Sum Check Node Unit

This block performs the check-node half of a scaled min-sum LDPC decoding iteration for one check node whose degree is set at run time, up to a parameterised maximum. A check node sees a set of edges, one per connected variable node. For every edge the unit receives the current posterior value of that variable and the check-to-variable message this check node sent on that edge in the previous iteration. On the first iteration those inputs are the channel LLRs and zero.

Work is split into two passes. In the gather pass the edges stream in one per cycle. The unit subtracts the old check message from the posterior to form the variable-to-check message and stores it. At the same time it tracks the running sign parity, the smallest magnitude, the edge that holds it, and the second-smallest magnitude. In the emit pass the unit replays the edges in arrival order. For each edge it sends out the new check message: the sign product and the minimum magnitude of all the other edges, scaled by 0.75. It also sends out the refreshed posterior, which is the stored variable-to-check message plus the new check message.

Many copies run side by side, one per row of a circulant sub-matrix. Message memories, address generation, syndrome checks and iteration control all sit outside the block.

Top module: `minsum_check_node`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The variable-to-check message of an edge is in_app minus in_ctv, clipped to the message range.
- R3: The sign of out_ctv for edge j is the XOR of the sign bits of the variable-to-check messages of every other edge. A message is negative when its top bit is 1, and zero counts as positive. A zero magnitude gives out_ctv = 0.
- R4: The excluded minimum for edge j is the second-smallest magnitude when j is the minimum edge, and the smallest magnitude otherwise. The minimum edge is the earliest edge holding the smallest magnitude, so when two edges tie, both receive that tied value.
- R5: The out_ctv magnitude is m - (m >> 2), where m is the excluded minimum.
- R6: out_app equals the variable-to-check message plus out_ctv, clipped to the message range.
- R7: All messages are two's complement W-bit values clipped to ±(2^(W-1)-1). The most negative code never appears on out_ctv or out_app.
- R8: A handshake with in_last set ends the gather pass. During the emit pass in_ready is 0 and out_valid is 1. out_last marks the final edge. After that edge's handshake, in_ready returns to 1 in the next cycle.
- R9: While out_valid is 1 and out_ready is 0, out_ctv, out_app and out_last hold their values.
- R10: The handshake of edge number MAX_DEG ends the gather pass even when in_last is 0.
- R11: in_valid, in_last and the input data have no effect during the emit pass. Neither the current results nor the next node's results change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Edge input available |
| in_ready | output | 1 | Unit is in the gather pass and accepts an edge |
| in_last | input | 1 | Current edge is the last of this check node |
| in_app | input | W | Posterior value of the edge's variable |
| in_ctv | input | W | Previous check-to-variable message on the edge |
| out_valid | output | 1 | Emit pass; the result for one edge is presented |
| out_ready | input | 1 | Downstream takes the presented result |
| out_last | output | 1 | Presented result belongs to the final edge |
| out_ctv | output | W | New scaled check-to-variable message |
| out_app | output | W | Updated posterior value |

## Verification
Two things can land in the same cycle. One is a new magnitude that equals the current minimum, which makes the tracker choose between replacing the smallest value and the second-smallest. The other is the final emit handshake, which meets a sender that is still holding in_valid. The bench provokes the first with a node in which two edges share the smallest magnitude, and passes only if both of those edges receive that magnitude scaled. It provokes the second by keeping in_valid and random data asserted throughout an emit pass. It then checks that in_ready rises only after out_last is taken, and that the next node's results match the reference model exactly.

// File: rtl/minsum_cn_pkg.sv
package minsum_cn_pkg;

   typedef enum logic {
      PH_GATHER = 1'b0,
      PH_EMIT   = 1'b1
   } cn_phase_e;

   // Largest magnitude of a symmetric W-bit message.
   function automatic int unsigned cn_mag_limit(int unsigned w);
      return (32'd1 << (w - 1)) - 32'd1;
   endfunction

endpackage

// File: rtl/cn_v2c_sub.sv
module cn_v2c_sub #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] app_i,
   input  logic [W-1:0] ctv_i,
   output logic [W-1:0] v2c_o,
   output logic         sign_o,
   output logic [W-2:0] mag_o
);
   localparam int unsigned LIM = minsum_cn_pkg::cn_mag_limit(W);
   localparam logic signed [W:0] POS_LIM = (W+1)'(LIM);
   localparam logic signed [W:0] NEG_LIM = -POS_LIM;

   logic signed [W:0] diff;
   logic [W-1:0]      neg_v;

   always_comb begin
      diff = $signed({app_i[W-1], app_i}) - $signed({ctv_i[W-1], ctv_i});
      if (diff > POS_LIM)
         v2c_o = POS_LIM[W-1:0];
      else if (diff < NEG_LIM)
         v2c_o = NEG_LIM[W-1:0];
      else
         v2c_o = diff[W-1:0];
      neg_v  = W'(0) - v2c_o;
      sign_o = v2c_o[W-1];
      mag_o  = v2c_o[W-1] ? neg_v[W-2:0] : v2c_o[W-2:0];
   end
endmodule

// File: rtl/cn_two_min.sv
module cn_two_min #(
   parameter int unsigned W       = 8,
   parameter int unsigned MAX_DEG = 32,
   localparam int unsigned IW     = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          upd_i,
   input  logic [W-2:0]  mag_i,
   input  logic          sign_i,
   input  logic [IW-1:0] idx_i,
   output logic [W-2:0]  min1_o,
   output logic [W-2:0]  min2_o,
   output logic [IW-1:0] min1_idx_o,
   output logic          parity_o
);
   localparam logic [W-2:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         min1_o     <= TOP;
         min2_o     <= TOP;
         min1_idx_o <= '0;
         parity_o   <= 1'b0;
      end else if (upd_i) begin
         parity_o <= parity_o ^ sign_i;
         if (mag_i < min1_o) begin
            min2_o     <= min1_o;
            min1_o     <= mag_i;
            min1_idx_o <= idx_i;
         end else if (mag_i < min2_o) begin
            min2_o <= mag_i;
         end
      end
   end
endmodule

// File: rtl/cn_edge_store.sv
module cn_edge_store #(
   parameter int unsigned W       = 8,
   parameter int unsigned MAX_DEG = 32,
   localparam int unsigned IW     = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [W-1:0]  wr_data_i,
   input  logic [IW-1:0] rd_idx_i,
   output logic [W-1:0]  rd_data_o
);
   logic [W-1:0] slot_q [MAX_DEG];

   for (genvar e = 0; e < MAX_DEG; e++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en_i && wr_idx_i == IW'(e))
            q <= wr_data_i;
      end
      assign slot_q[e] = q;
   end

   assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/cn_emit.sv
module cn_emit #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] v2c_i,
   input  logic [W-2:0] min1_i,
   input  logic [W-2:0] min2_i,
   input  logic         is_min_edge_i,
   input  logic         parity_i,
   output logic [W-1:0] ctv_o,
   output logic [W-1:0] app_o
);
   localparam int unsigned LIM = minsum_cn_pkg::cn_mag_limit(W);
   localparam logic signed [W:0] POS_LIM = (W+1)'(LIM);
   localparam logic signed [W:0] NEG_LIM = -POS_LIM;

   logic [W-2:0]      excl;
   logic [W-2:0]      scaled;
   logic [W-1:0]      pos_ctv;
   logic              neg;
   logic signed [W:0] sum;

   always_comb begin
      excl    = is_min_edge_i ? min2_i : min1_i;
      scaled  = excl - (excl >> 2);
      pos_ctv = {1'b0, scaled};
      neg     = parity_i ^ v2c_i[W-1];
      ctv_o   = neg ? (W'(0) - pos_ctv) : pos_ctv;
      sum     = $signed({v2c_i[W-1], v2c_i}) + $signed({ctv_o[W-1], ctv_o});
      if (sum > POS_LIM)
         app_o = POS_LIM[W-1:0];
      else if (sum < NEG_LIM)
         app_o = NEG_LIM[W-1:0];
      else
         app_o = sum[W-1:0];
   end
endmodule

// File: rtl/minsum_check_node.sv
module minsum_check_node #(
   parameter int unsigned W       = 8,
   parameter int unsigned MAX_DEG = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic         in_last,
   input  logic [W-1:0] in_app,
   input  logic [W-1:0] in_ctv,
   output logic         out_valid,
   input  logic         out_ready,
   output logic         out_last,
   output logic [W-1:0] out_ctv,
   output logic [W-1:0] out_app
);
   import minsum_cn_pkg::*;

   localparam int unsigned IW = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
   localparam logic [IW-1:0] LAST_SLOT = IW'(MAX_DEG - 1);

   if (W < 4 || W > 16) begin : g_bad_width
      $error("minsum_check_node: W must lie in 4..16");
   end
   if (MAX_DEG < 2) begin : g_bad_degree
      $error("minsum_check_node: MAX_DEG must be at least 2");
   end

   cn_phase_e     phase_q;
   logic [IW-1:0] wr_cnt_q;
   logic [IW-1:0] last_idx_q;
   logic [IW-1:0] rd_cnt_q;

   logic          accept;
   logic          gather_done;
   logic          emit_fire;
   logic          emit_done;

   logic [W-1:0]  v2c_new;
   logic          v2c_sign;
   logic [W-2:0]  v2c_mag;
   logic [W-1:0]  v2c_rd;
   logic [W-2:0]  min1;
   logic [W-2:0]  min2;
   logic [IW-1:0] min1_idx;
   logic          parity;

   assign in_ready    = (phase_q == PH_GATHER);
   assign out_valid   = (phase_q == PH_EMIT);
   assign accept      = in_valid && in_ready;
   assign gather_done = accept && (in_last || wr_cnt_q == LAST_SLOT);
   assign out_last    = out_valid && (rd_cnt_q == last_idx_q);
   assign emit_fire   = out_valid && out_ready;
   assign emit_done   = emit_fire && out_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= PH_GATHER;
         wr_cnt_q   <= '0;
         last_idx_q <= '0;
         rd_cnt_q   <= '0;
      end else begin
         if (gather_done) begin
            phase_q    <= PH_EMIT;
            last_idx_q <= wr_cnt_q;
            wr_cnt_q   <= '0;
            rd_cnt_q   <= '0;
         end else if (accept) begin
            wr_cnt_q <= wr_cnt_q + IW'(1);
         end
         if (emit_done) begin
            phase_q  <= PH_GATHER;
            rd_cnt_q <= '0;
         end else if (emit_fire) begin
            rd_cnt_q <= rd_cnt_q + IW'(1);
         end
      end
   end

   cn_v2c_sub #(.W(W)) u_sub (
      .app_i  (in_app),
      .ctv_i  (in_ctv),
      .v2c_o  (v2c_new),
      .sign_o (v2c_sign),
      .mag_o  (v2c_mag)
   );

   cn_two_min #(.W(W), .MAX_DEG(MAX_DEG)) u_min (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (emit_done),
      .upd_i      (accept),
      .mag_i      (v2c_mag),
      .sign_i     (v2c_sign),
      .idx_i      (wr_cnt_q),
      .min1_o     (min1),
      .min2_o     (min2),
      .min1_idx_o (min1_idx),
      .parity_o   (parity)
   );

   cn_edge_store #(.W(W), .MAX_DEG(MAX_DEG)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (accept),
      .wr_idx_i  (wr_cnt_q),
      .wr_data_i (v2c_new),
      .rd_idx_i  (rd_cnt_q),
      .rd_data_o (v2c_rd)
   );

   cn_emit #(.W(W)) u_emit (
      .v2c_i         (v2c_rd),
      .min1_i        (min1),
      .min2_i        (min2),
      .is_min_edge_i (rd_cnt_q == min1_idx),
      .parity_i      (parity),
      .ctv_o         (out_ctv),
      .app_o         (out_app)
   );
endmodule

// File: rtl/minsum_cn_chk.sv
module minsum_cn_chk #(
   parameter int unsigned W       = 8,
   parameter int unsigned MAX_DEG = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         in_ready,
   input logic         in_last,
   input logic         out_valid,
   input logic         out_ready,
   input logic         out_last,
   input logic [W-1:0] out_ctv,
   input logic [W-1:0] out_app
);
   localparam int unsigned IW = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   logic [IW-1:0] seen_q;
   logic          take;

   assign take = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)
         seen_q <= '0;
      else if (take)
         seen_q <= (in_last || seen_q == IW'(MAX_DEG - 1)) ? '0 : seen_q + IW'(1);
   end

   // R8
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R8
   last_to_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_last) |=> (out_valid && !in_ready));

   // R8
   emit_to_gather_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_ctv) && $stable(out_app) && $stable(out_last)));

   // R7
   no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ctv != MOST_NEG && out_app != MOST_NEG));

   // R10
   forced_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && seen_q == IW'(MAX_DEG - 1)) |=> out_valid);
endmodule

bind minsum_check_node minsum_cn_chk #(.W(W), .MAX_DEG(MAX_DEG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_last  (out_last),
   .out_ctv   (out_ctv),
   .out_app   (out_app)
);

// File: tb/minsum_check_node_bench.sv
module minsum_check_node_bench;
   localparam int W       = 8;
   localparam int MAX_DEG = 32;
   localparam int LIM     = (1 << (W - 1)) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic         in_last = 1'b0;
   logic [W-1:0] in_app = '0;
   logic [W-1:0] in_ctv = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic         out_last;
   logic [W-1:0] out_ctv;
   logic [W-1:0] out_app;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   int g_app [MAX_DEG];
   int g_ctv [MAX_DEG];

   always #2 clk = ~clk;

   minsum_check_node #(.W(W), .MAX_DEG(MAX_DEG)) u_minsum_check_node (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
      .in_app(in_app), .in_ctv(in_ctv),
      .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
      .out_ctv(out_ctv), .out_app(out_app)
   );

   function automatic int clip(int v);
      if (v > LIM) return LIM;
      if (v < -LIM) return -LIM;
      return v;
   endfunction

   function automatic int to_int(logic [W-1:0] v);
      return int'($signed(v));
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drives one check node of degree deg from g_app/g_ctv and compares every result.
   task automatic run_node(int deg, bit send_last, bit stall, bit noise, string tag);
      int v2c [MAX_DEG];
      int e_ctv [MAX_DEG];
      int e_app [MAX_DEG];
      int m1, m2, i1, par, m, s, c;
      m1 = LIM; m2 = LIM; i1 = 0; par = 0;
      for (int k = 0; k < deg; k++) begin
         v2c[k] = clip(g_app[k] - g_ctv[k]);
         m = (v2c[k] < 0) ? -v2c[k] : v2c[k];
         par ^= (v2c[k] < 0) ? 1 : 0;
         if (m < m1) begin m2 = m1; m1 = m; i1 = k; end
         else if (m < m2) m2 = m;
      end
      for (int j = 0; j < deg; j++) begin
         m = (j == i1) ? m2 : m1;
         s = m - (m >> 2);
         c = ((par ^ ((v2c[j] < 0) ? 1 : 0)) != 0) ? -s : s;
         e_ctv[j] = c;
         e_app[j] = clip(v2c[j] + c);
      end
      for (int k = 0; k < deg; k++) begin
         @(negedge clk);
         chk(in_ready == 1'b1, {tag, " R8 in_ready in gather"}, int'(in_ready), 1);
         in_valid = 1'b1;
         in_app   = W'(g_app[k]);
         in_ctv   = W'(g_ctv[k]);
         in_last  = send_last && (k == deg - 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      for (int j = 0; j < deg; j++) begin
         if (noise) begin
            in_valid = 1'b1;
            in_last  = 1'($urandom_range(0, 1));
            in_app   = W'($urandom_range(0, 255));
            in_ctv   = W'($urandom_range(0, 255));
         end
         chk(in_ready == 1'b0, {tag, " R8/R11 in_ready low in emit"}, int'(in_ready), 0);
         if (stall && (j % 3 == 0)) begin
            out_ready = 1'b0;
            @(negedge clk);
            chk(to_int(out_ctv) == e_ctv[j], {tag, " R9 held ctv"}, to_int(out_ctv), e_ctv[j]);
            chk(to_int(out_app) == e_app[j], {tag, " R9 held app"}, to_int(out_app), e_app[j]);
         end
         out_ready = 1'b1;
         chk(out_valid == 1'b1, {tag, " R8 out_valid"}, int'(out_valid), 1);
         chk(to_int(out_ctv) == e_ctv[j], {tag, " R3/R4/R5 ctv"}, to_int(out_ctv), e_ctv[j]);
         chk(to_int(out_app) == e_app[j], {tag, " R2/R6/R7 app"}, to_int(out_app), e_app[j]);
         chk(out_last == (j == deg - 1), {tag, " R8 out_last"}, int'(out_last), int'(j == deg - 1));
         if (j == deg - 1) begin
            in_valid = 1'b0;
            in_last  = 1'b0;
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(in_ready == 1'b1, {tag, " R8 back to gather"}, int'(in_ready), 1);
      chk(out_valid == 1'b0, {tag, " R8 emit over"}, int'(out_valid), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
   endtask

   task automatic t_first_iteration();
      // R2 R3 R5: ctv inputs zero, mixed signs
      int a [4] = '{12, -30, 7, 50};
      for (int k = 0; k < 4; k++) begin g_app[k] = a[k]; g_ctv[k] = 0; end
      run_node(4, 1'b1, 1'b0, 1'b0, "first");
   endtask

   task automatic t_tie();
      // R4: two edges share the smallest magnitude
      int a [5] = '{9, -3, 3, -20, 7};
      for (int k = 0; k < 5; k++) begin g_app[k] = a[k]; g_ctv[k] = 0; end
      run_node(5, 1'b1, 1'b0, 1'b0, "tie");
   endtask

   task automatic t_saturate();
      // R7 R2 R6: clipping on subtraction and on the posterior sum
      g_app[0] = 127;  g_ctv[0] = -100;
      g_app[1] = -127; g_ctv[1] = 100;
      g_app[2] = 120;  g_ctv[2] = 0;
      run_node(3, 1'b1, 1'b0, 1'b0, "sat_a");
      g_app[0] = 120; g_ctv[0] = 0;
      g_app[1] = 110; g_ctv[1] = 0;
      g_app[2] = 100; g_ctv[2] = 0;
      run_node(3, 1'b1, 1'b0, 1'b0, "sat_b");
   endtask

   task automatic t_stall();
      // R9
      for (int k = 0; k < 7; k++) begin
         g_app[k] = $urandom_range(0, 254) - 127;
         g_ctv[k] = $urandom_range(0, 80) - 40;
      end
      run_node(7, 1'b1, 1'b1, 1'b0, "stall");
   endtask

   task automatic t_noise();
      // R11: input activity during emit, then a clean node right after
      for (int k = 0; k < 6; k++) begin
         g_app[k] = $urandom_range(0, 254) - 127;
         g_ctv[k] = $urandom_range(0, 60) - 30;
      end
      run_node(6, 1'b1, 1'b0, 1'b1, "noise_a");
      for (int k = 0; k < 4; k++) begin
         g_app[k] = $urandom_range(0, 254) - 127;
         g_ctv[k] = 0;
      end
      run_node(4, 1'b1, 1'b0, 1'b0, "noise_b");
   endtask

   task automatic t_max_degree();
      // R10: no in_last, the unit ends the pass on its own
      for (int k = 0; k < MAX_DEG; k++) begin
         g_app[k] = $urandom_range(0, 254) - 127;
         g_ctv[k] = $urandom_range(0, 60) - 30;
      end
      run_node(MAX_DEG, 1'b0, 1'b0, 1'b0, "maxdeg");
   endtask

   task automatic t_random();
      for (int r = 0; r < 8; r++) begin
         int d = $urandom_range(2, MAX_DEG);
         for (int k = 0; k < d; k++) begin
            g_app[k] = $urandom_range(0, 254) - 127;
            g_ctv[k] = $urandom_range(0, 120) - 60;
         end
         run_node(d, 1'b1, (r % 2) == 1, (r % 3) == 2, "random");
      end
   endtask

   initial begin
      process::self().srandom(17);
      t_reset();
      t_first_iteration();
      t_tie();
      t_saturate();
      t_stall();
      t_noise();
      t_max_degree();
      t_random();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule